// File: doc/BRIEF.md
# Double-Buffered Programmable Serial Frame Transmitter

This block turns a parallel character into an asynchronous serial frame on one output line. It runs from a single clock at sixteen times the bit rate, so every serial bit lasts sixteen clock cycles. A frame starts with a low start bit. The character follows, least significant bit first, then an optional parity bit, then one, one and a half, or two high stop bits. The frame format comes from a control word that is held in an internal register. That register is written while a control-load input is high, and the transmitter only ever reads the stored copy.

The host writes characters through an active-low load strobe. While the strobe is low, the data input is copied into a holding register. The strobe is synchronised into the clock domain, and its rising edge is detected there. That edge marks the holding register as occupied and drops the buffer-empty flag. If the shift engine is idle, the character moves into it right away. If it is busy, the character waits and starts on the same clock edge that ends the current frame, so two characters go out with no gap between them. A shift-register-empty flag reports when the line has fully finished the last stop bit.

Top module: `serial_frame_tx`

## Requirements
- R1: Every serial bit lasts exactly 16 clock cycles. A frame is a low start bit, then the character bits least significant first, then the parity bit if enabled, then high stop bits.
- R2: `cfg_len` sets the character length: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data input bits above the chosen length have no effect on the frame.
- R3: When `cfg_par_off` is 1, no parity bit is sent. When it is 0, a parity bit follows the last data bit. With `cfg_par_even` = 1 the number of ones across data and parity is even; with 0 it is odd.
- R4: When `cfg_stop_sel` is 0, the stop time is 16 cycles. When it is 1, the stop time is 24 cycles for a 5-bit character and 32 cycles for any other length.
- R5: The control inputs are stored on every clock edge where `cfg_load` is 1, and are ignored otherwise. A frame uses the stored values that are present when it is moved into the shift engine.
- R6: On every clock edge where `load_n` is 0, `tx_data` is copied into the holding register. After `load_n` rises, `hold_empty` falls on the third clock edge.
- R7: If the shift engine is idle, the fourth clock edge after `load_n` rises moves the character in. On that edge `shift_empty` falls and the start bit begins. `hold_empty` returns high on the fifth edge.
- R8: A character loaded during a frame starts its start bit on the exact edge where the previous frame's last stop cycle ends. `shift_empty` stays low between the two frames.
- R9: `shift_empty` rises on the edge that ends the last stop cycle, which is a whole frame length after the start bit began. `tx_line` is high whenever `shift_empty` is high.
- R10: On any clock edge where `rst` is 1, `tx_line`, `hold_empty` and `shift_empty` are set high. Any character that is in flight or waiting is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 16 times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Stores the control inputs while high |
| cfg_len | input | 2 | Character length select |
| cfg_par_off | input | 1 | 1 leaves the parity bit out |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_stop_sel | input | 1 | 1 selects the longer stop time |
| load_n | input | 1 | Active-low character load strobe |
| tx_data | input | 8 | Character, right-justified to bit 0 |
| tx_line | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding register can accept a character |
| shift_empty | output | 1 | No frame is being sent |

## Verification
After `load_n` rises, `hold_empty` falls on the third clock edge. On the fourth edge `shift_empty` and `tx_line` fall, and on the fifth edge `hold_empty` rises again. The bench samples on falling clock edges and checks each flag on the falling edge that follows the rising edge where it is due. Frame bits are read at the middle of each 16-cycle bit, eight cycles after the falling edge of the start bit. The frame length is counted in falling edges, from the first low sample up to the first sample where `shift_empty` is high. For back-to-back characters, the next start bit is checked at exactly one frame length.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

    localparam int CHAR_MAX  = 8;
    localparam int FRAME_MAX = 12;

    typedef enum logic [1:0] {
        LEN5 = 2'b00,
        LEN6 = 2'b01,
        LEN7 = 2'b10,
        LEN8 = 2'b11
    } len_e;

    typedef struct packed {
        len_e len;
        logic par_off;
        logic par_even;
        logic stop_sel;
    } cfg_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [3:0]           body_bits;
        logic [2:0]           stop_halves;
    } frame_t;

    localparam cfg_t CFG_RESET = '{len: LEN8, par_off: 1'b1, par_even: 1'b0, stop_sel: 1'b0};

    function automatic int char_len(len_e l);
        return 5 + int'(l);
    endfunction

    function automatic frame_t build_frame(cfg_t c, logic [CHAR_MAX-1:0] d);
        frame_t f;
        int     n;
        logic   p;
        n           = char_len(c.len);
        p           = 1'b0;
        f.bits      = '1;
        f.bits[0]   = 1'b0;
        for (int i = 0; i < CHAR_MAX; i++) begin
            if (i < n) begin
                f.bits[1+i] = d[i];
                p           = p ^ d[i];
            end
        end
        if (!c.par_off) begin
            f.bits[1+n] = c.par_even ? p : ~p;
        end
        f.body_bits   = 4'(1 + n + (c.par_off ? 0 : 1));
        if (!c.stop_sel) begin
            f.stop_halves = 3'd2;
        end else if (c.len == LEN5) begin
            f.stop_halves = 3'd3;
        end else begin
            f.stop_halves = 3'd4;
        end
        return f;
    endfunction

endpackage

// File: rtl/sftx_ctrl_reg.sv
module sftx_ctrl_reg
    import sftx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] len,
    input  logic       par_off,
    input  logic       par_even,
    input  logic       stop_sel,
    output cfg_t       cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (wr) begin
            cfg.len      <= len_e'(len);
            cfg.par_off  <= par_off;
            cfg.par_even <= par_even;
            cfg.stop_sel <= stop_sel;
        end
    end

endmodule

// File: rtl/sftx_strobe_sync.sv
module sftx_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '1;
            last_q <= 1'b1;
        end else begin
            chain  <= {chain[STAGES-2:0], strobe_n};
            last_q <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/sftx_hold_buf.sv
module sftx_hold_buf
    import sftx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_n,
    input  logic [CHAR_MAX-1:0] din,
    input  logic                rise,
    input  logic                ready,
    output logic                xfer,
    output logic [CHAR_MAX-1:0] dout,
    output logic                empty
);

    logic pend_q;
    logic moved_q;
    logic empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (!load_n) begin
            dout <= din;
        end
    end

    assign xfer = pend_q & ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            moved_q <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            moved_q <= xfer;
            if (rise) begin
                pend_q <= 1'b1;
            end else if (xfer) begin
                pend_q <= 1'b0;
            end
            if (rise) begin
                empty_q <= 1'b0;
            end else if (moved_q) begin
                empty_q <= 1'b1;
            end
        end
    end

    assign empty = empty_q;

endmodule

// File: rtl/sftx_shifter.sv
module sftx_shifter
    import sftx_pkg::*;
#(
    parameter int BIT_TICKS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  cfg_t                cfg,
    input  logic [CHAR_MAX-1:0] data,
    output logic                ready,
    output logic                line,
    output logic                empty
);

    localparam int PH_W      = $clog2(BIT_TICKS);
    localparam int MAX_TICKS = BIT_TICKS * FRAME_MAX;
    localparam int RM_W      = $clog2(MAX_TICKS + 1);

    frame_t                fr;
    logic [RM_W-1:0]       total;
    logic [FRAME_MAX-1:0]  sh_q;
    logic [PH_W-1:0]       phase_q;
    logic [RM_W-1:0]       remain_q;
    logic                  empty_q;
    logic                  done;
    logic                  ph_last;

    always_comb begin
        fr    = build_frame(cfg, data);
        total = RM_W'(int'(fr.body_bits) * BIT_TICKS
                      + int'(fr.stop_halves) * (BIT_TICKS / 2));
    end

    assign ph_last = (phase_q == PH_W'(BIT_TICKS - 1));
    assign done    = ~empty_q & (remain_q == '0);
    assign ready   = empty_q | done;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '1;
            empty_q  <= 1'b1;
            phase_q  <= '0;
            remain_q <= '0;
        end else if (load) begin
            sh_q     <= fr.bits;
            empty_q  <= 1'b0;
            phase_q  <= '0;
            remain_q <= total - RM_W'(1);
        end else if (done) begin
            empty_q  <= 1'b1;
        end else if (!empty_q) begin
            phase_q  <= phase_q + PH_W'(1);
            remain_q <= remain_q - RM_W'(1);
            if (ph_last) begin
                sh_q <= {1'b1, sh_q[FRAME_MAX-1:1]};
            end
        end
    end

    assign line  = sh_q[0];
    assign empty = empty_q;

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sftx_pkg::*;
#(
    parameter int BIT_TICKS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_load,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_off,
    input  logic       cfg_par_even,
    input  logic       cfg_stop_sel,
    input  logic       load_n,
    input  logic [7:0] tx_data,
    output logic       tx_line,
    output logic       hold_empty,
    output logic       shift_empty
);

    cfg_t                cfg;
    logic                rise;
    logic                ready;
    logic                xfer;
    logic [CHAR_MAX-1:0] held;

    sftx_ctrl_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_load),
        .len      (cfg_len),
        .par_off  (cfg_par_off),
        .par_even (cfg_par_even),
        .stop_sel (cfg_stop_sel),
        .cfg      (cfg)
    );

    sftx_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (load_n),
        .rise     (rise)
    );

    sftx_hold_buf u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_n (load_n),
        .din    (tx_data),
        .rise   (rise),
        .ready  (ready),
        .xfer   (xfer),
        .dout   (held),
        .empty  (hold_empty)
    );

    sftx_shifter #(.BIT_TICKS(BIT_TICKS)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (xfer),
        .cfg   (cfg),
        .data  (held),
        .ready (ready),
        .line  (tx_line),
        .empty (shift_empty)
    );

endmodule

// File: rtl/sftx_chk.sv
module sftx_chk (
    input logic clk,
    input logic rst,
    input logic tx_line,
    input logic hold_empty,
    input logic shift_empty
);

    // R9
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        shift_empty |-> tx_line);

    // R1
    start_on_load_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_empty) |-> !tx_line);

    // R7
    xfer_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_empty) |-> !hold_empty);

    // R7
    empty_after_move_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_empty) |=> hold_empty);

    // R8
    chain_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_empty && !shift_empty) |=> !shift_empty);

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (tx_line && hold_empty && shift_empty));

endmodule

bind serial_frame_tx sftx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_line     (tx_line),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty)
);

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load = 1'b0;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_off = 1'b1;
    logic       cfg_par_even = 1'b0;
    logic       cfg_stop_sel = 1'b0;
    logic       load_n = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       tx_line;
    logic       hold_empty;
    logic       shift_empty;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_frame_tx u0 (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_len(cfg_len),
        .cfg_par_off(cfg_par_off), .cfg_par_even(cfg_par_even),
        .cfg_stop_sel(cfg_stop_sel), .load_n(load_n), .tx_data(tx_data),
        .tx_line(tx_line), .hold_empty(hold_empty), .shift_empty(shift_empty)
    );

    // {len[1:0], par_off, par_even, stop_sel, data[7:0]}
    localparam logic [12:0] VECS [8] = '{
        {2'b11, 1'b0, 1'b1, 1'b0, 8'hA5},
        {2'b11, 1'b0, 1'b0, 1'b1, 8'h3C},
        {2'b00, 1'b0, 1'b1, 1'b1, 8'hE5},
        {2'b00, 1'b1, 1'b0, 1'b0, 8'h1F},
        {2'b01, 1'b0, 1'b0, 1'b0, 8'hFF},
        {2'b10, 1'b1, 1'b1, 1'b1, 8'h55},
        {2'b01, 1'b0, 1'b1, 1'b1, 8'h2A},
        {2'b10, 1'b0, 1'b0, 1'b0, 8'h00}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_frame(input logic [7:0] d, input logic [1:0] len,
                                input logic poff, input logic peven, input logic ssel,
                                output logic [11:0] bits, output int nb, output int total);
        int n;
        int ones;
        n = 5 + int'(len);
        ones = 0;
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < n; i++) begin
            bits[1+i] = d[i];
            if (d[i]) ones++;
        end
        if (!poff) bits[1+n] = peven ? ((ones % 2) == 1) : ((ones % 2) == 0);
        nb = 2 + n + (poff ? 0 : 1);
        total = 16 * (nb - 1);
        if (!ssel) total += 16;
        else if (n == 5) total += 24;
        else total += 32;
    endtask

    task automatic set_cfg(input logic [1:0] len, input logic poff,
                           input logic peven, input logic ssel);
        @(negedge clk);
        cfg_len = len; cfg_par_off = poff; cfg_par_even = peven; cfg_stop_sel = ssel;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic load_char(input logic [7:0] d);
        @(negedge clk);
        tx_data = d;
        load_n = 1'b0;
        @(negedge clk);
        load_n = 1'b1;
    endtask

    task automatic check_frame(input logic [7:0] d, input logic [1:0] len,
                               input logic poff, input logic peven, input logic ssel,
                               input string req_bits, input string req_len);
        logic [11:0] exp_bits;
        logic [11:0] got;
        logic [11:0] mask;
        int nb;
        int total;
        int k;
        int wait_n;
        expect_frame(d, len, poff, peven, ssel, exp_bits, nb, total);
        wait_n = 0;
        while (tx_line && wait_n < 64) begin
            @(negedge clk);
            wait_n++;
        end
        check(!tx_line, req_bits, "start bit seen", longint'(tx_line), 0);
        got = '1;
        k = 0;
        while (k <= 400) begin
            if ((k % 16) == 8 && (k / 16) < nb) got[k/16] = tx_line;
            if (shift_empty) break;
            @(negedge clk);
            k++;
        end
        mask = 12'((1 << nb) - 1);
        check((got & mask) == (exp_bits & mask), req_bits, "frame bits",
              longint'(got & mask), longint'(exp_bits & mask));
        check(k == total, req_len, "frame cycles", longint'(k), longint'(total));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] ea, eb, ga, gb;
        int nba, nbb, ta, tb, k, lows;
        logic bstart, seen_empty, end_empty;

        // R10 reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_line == 1'b1, "R10", "tx_line after reset", longint'(tx_line), 1);
        check(hold_empty == 1'b1, "R10", "hold_empty after reset", longint'(hold_empty), 1);
        check(shift_empty == 1'b1, "R10", "shift_empty after reset", longint'(shift_empty), 1);

        // R1 R2 R3 R4: table of formats
        for (int v = 0; v < 8; v++) begin
            set_cfg(VECS[v][12:11], VECS[v][10], VECS[v][9], VECS[v][8]);
            load_char(VECS[v][7:0]);
            check_frame(VECS[v][7:0], VECS[v][12:11], VECS[v][10], VECS[v][9], VECS[v][8],
                        "R1/R2/R3", "R4");
            repeat (5) @(negedge clk);
        end

        // R6 R7 load handshake timing with an idle shift engine
        set_cfg(2'b11, 1'b0, 1'b1, 1'b0);
        @(negedge clk); tx_data = 8'h5A; load_n = 1'b0;
        @(negedge clk); load_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(hold_empty == 1'b1, "R6", "hold_empty two edges after rise", longint'(hold_empty), 1);
        @(negedge clk);
        check(hold_empty == 1'b0, "R6", "hold_empty third edge", longint'(hold_empty), 0);
        check(shift_empty == 1'b1, "R7", "shift_empty third edge", longint'(shift_empty), 1);
        @(negedge clk);
        check(shift_empty == 1'b0, "R7", "shift_empty fourth edge", longint'(shift_empty), 0);
        check(tx_line == 1'b0, "R7", "start bit fourth edge", longint'(tx_line), 0);
        check(hold_empty == 1'b0, "R7", "hold_empty fourth edge", longint'(hold_empty), 0);
        @(negedge clk);
        check(hold_empty == 1'b1, "R7", "hold_empty fifth edge", longint'(hold_empty), 1);
        while (!shift_empty) @(negedge clk);

        // R6 last value captured while load_n low wins
        @(negedge clk); tx_data = 8'h11; load_n = 1'b0;
        @(negedge clk); tx_data = 8'h22;
        @(negedge clk); tx_data = 8'h96;
        @(negedge clk); load_n = 1'b1;
        check_frame(8'h96, 2'b11, 1'b0, 1'b1, 1'b0, "R6", "R6");

        // R5 unlatched control inputs have no effect
        set_cfg(2'b11, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        cfg_len = 2'b00; cfg_par_off = 1'b0; cfg_par_even = 1'b1; cfg_stop_sel = 1'b1;
        load_char(8'hC3);
        check_frame(8'hC3, 2'b11, 1'b1, 1'b0, 1'b0, "R5", "R5");

        // R8 back-to-back characters, R9 end of last stop
        set_cfg(2'b11, 1'b1, 1'b0, 1'b0);
        expect_frame(8'h81, 2'b11, 1'b1, 1'b0, 1'b0, ea, nba, ta);
        expect_frame(8'h7E, 2'b11, 1'b1, 1'b0, 1'b0, eb, nbb, tb);
        load_char(8'h81);
        k = 0;
        while (tx_line && k < 64) begin @(negedge clk); k++; end
        ga = '1; gb = '1; bstart = 1'b1; seen_empty = 1'b0; end_empty = 1'b0;
        k = 0;
        while (k <= ta + tb) begin
            if (k == 2) begin tx_data = 8'h7E; load_n = 1'b0; end
            if (k == 3) load_n = 1'b1;
            if (k < ta && (k % 16) == 8 && (k / 16) < nba) ga[k/16] = tx_line;
            if (k >= ta && ((k - ta) % 16) == 8 && ((k - ta) / 16) < nbb) gb[(k-ta)/16] = tx_line;
            if (k == ta) bstart = tx_line;
            if (k > 0 && k < ta + tb && shift_empty) seen_empty = 1'b1;
            if (k == ta + tb) end_empty = shift_empty;
            @(negedge clk);
            k++;
        end
        check(ga[9:0] == ea[9:0], "R8", "first frame bits", longint'(ga[9:0]), longint'(ea[9:0]));
        check(bstart == 1'b0, "R8", "second start at frame end", longint'(bstart), 0);
        check(seen_empty == 1'b0, "R8", "no idle between frames", longint'(seen_empty), 0);
        check(gb[9:0] == eb[9:0], "R8", "second frame bits", longint'(gb[9:0]), longint'(eb[9:0]));
        check(end_empty == 1'b1, "R9", "shift_empty at end of second", longint'(end_empty), 1);

        // R10 reset during a frame with a character waiting
        load_char(8'hF0);
        repeat (40) @(negedge clk);
        load_char(8'h0F);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(tx_line == 1'b1, "R10", "tx_line after mid-frame reset", longint'(tx_line), 1);
        check(hold_empty == 1'b1, "R10", "hold_empty after mid-frame reset", longint'(hold_empty), 1);
        check(shift_empty == 1'b1, "R10", "shift_empty after mid-frame reset", longint'(shift_empty), 1);
        lows = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (!tx_line || !shift_empty) lows++;
        end
        check(lows == 0, "R10", "waiting character dropped", longint'(lows), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule